// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind one small CPU bus. The host writes a control word that picks a channel and one of six counting behaviours, then writes the 16-bit start count as two bytes: the low byte first, then the high byte. Each channel then counts on its own count-enable input, uses its gate input according to the chosen behaviour, and drives a single output. The output can be a level that rises at terminal count, a retriggerable one-shot pulse, a periodic one-tick low pulse, a square wave, or a one-tick strobe started by software or by the gate.

The bus is synchronous to the block clock. A write is taken in every clock cycle where chip select and write are low and read is high. A read cycle has chip select and read low and write high. During a read cycle the selected channel's current count comes back one byte at a time: low byte first, then high byte. Counting is binary only.

Top module: `tmr_multi_top`

## Requirements
- R1: After reset every output is high, no channel is configured, and count-enable pulses on an unconfigured channel leave its output high. A read of a channel returns 0.
- R2: Address 0, 1 and 2 select channels 0, 1 and 2, and address 3 is the control word. A cycle with chip select high, or with both read and write high, does nothing. A read at address 3 returns 0 and changes no state.
- R3: Control word layout: bits 7:6 give the channel index, bits 5:4 must be 11, bits 3:1 give the mode (0 to 5), and bit 0 must be 0. A word with channel index 3, with bits 5:4 other than 11, with mode 6 or 7, or with bit 0 set is ignored. An accepted word stops the channel and sets its output low for mode 0 and high for modes 1 to 5.
- R4: After a control word, the first data write to a channel sets the low byte and the second sets the high byte. A count written to a channel that is not in a gate-triggered mode is loaded at the first count-enable tick after the high byte is written. A count of 0 means 65536. The output changes only on a tick, on a bus write, or when the gate is low.
- R5: Mode 0 (interrupt at terminal count): the output stays low after the count is written. With N loaded, it goes high at the (N+1)th tick after the write and stays high.
- R6: In mode 0, ticks while the gate is low leave the count unchanged. Only ticks with the gate high count towards terminal count.
- R7: Mode 1 (one-shot): a rising gate edge, taken at the next tick, loads N and drives the output low. The output goes high again after N further ticks. A later edge retriggers.
- R8: Mode 2 (rate generator, N at least 2): the output is high and goes low for one tick out of every N, when the count is at 1. At that point the count reloads. While the gate is low the count holds and the output is forced high.
- R9: Mode 3 (square wave, N at least 2): the period is N ticks. The output is high for ceil(N/2) ticks and low for floor(N/2), so for odd N the high half is one tick longer.
- R10: Mode 4 (software strobe): the count is loaded at the first tick after the high byte. The output is low only for the tick after the count reaches 0, which is the (N+1)th tick, and is high otherwise.
- R11: Mode 5 (gate strobe): same waveform as mode 4, but the tick that loads the count is the first tick after a gate rising edge.
- R12: Reads of a channel alternate between the low and high byte of its current count, starting from the low byte after reset or after a control word for that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel or control word select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 outside a channel read |
| cnt_en | input | 3 | Per-channel count tick enable |
| gate | input | 3 | Per-channel gate |
| tmr_out | output | 3 | Per-channel output |

## Verification
The hardest cases to reach are the gate-dependent corners. These are the mode 0 count freezing partway through, the mode 3 output being forced high during its low half, and the gate-triggered modes, which must ignore the written count until an edge arrives. The bench reaches them by writing a control word with the gate held in a chosen level, loading small counts, and moving the gate at chosen tick numbers. It sweeps every mode on every channel over counts 1 to 7 and compares each tick's output against a closed-form expression of the tick index. A separate run with the count left at 0 goes through all 65537 ticks to reach the 65536 wrap.

// File: rtl/tmr_pkg.sv
// Shared types for the three-channel interval timer.
// Assumes: mode codes are the ones carried in control word bits 3:1.
package tmr_pkg;
    typedef enum logic [2:0] {
        M_TCINT    = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } tmr_mode_e;

    localparam int ADDR_W   = 2;
    localparam int MODE_W   = 3;
    localparam int MAX_MODE = 5;
endpackage

// File: rtl/tmr_bus_if.sv
// Bus decoder for the timer. It validates control words, steers data bytes
// to the channels with a low/high pointer per channel, and returns count
// bytes on reads.
// Assumes: one access per cycle, and NUM_CH <= 3 so that address 3 is the control word.
module tmr_bus_if
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
    output logic [DATA_W-1:0]       rdata,
    output logic [NUM_CH-1:0]       ctrl_wr,
    output logic [MODE_W-1:0]       ctrl_mode,
    output logic [NUM_CH-1:0]       lo_wr,
    output logic [NUM_CH-1:0]       hi_wr
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

    logic wr_cyc, rd_cyc, ctrl_ok;
    logic [NUM_CH-1:0] wptr_hi, rptr_hi, data_wr, data_rd;

    // Qualify bus cycles and the control word fields.
    always_comb begin
        wr_cyc    = !cs_n && !wr_n && rd_n;
        rd_cyc    = !cs_n && !rd_n && wr_n;
        ctrl_mode = wdata[3:1];
        ctrl_ok   = wr_cyc && (addr == CTRL_ADDR) && (wdata[5:4] == 2'b11)
                    && !wdata[0] && (int'(wdata[3:1]) <= MAX_MODE)
                    && (wdata[7:6] != 2'b11);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ctrl_wr[i] = ctrl_ok && (int'(wdata[7:6]) == i);
        assign data_wr[i] = wr_cyc && (int'(addr) == i);
        assign data_rd[i] = rd_cyc && (int'(addr) == i);
        assign lo_wr[i]   = data_wr[i] && !wptr_hi[i];
        assign hi_wr[i]   = data_wr[i] &&  wptr_hi[i];

        // Write byte pointer: cleared by a control word, toggled per data write.
        always_ff @(posedge clk) begin
            if (!rst_n)          wptr_hi[i] <= 1'b0;
            else if (ctrl_wr[i]) wptr_hi[i] <= 1'b0;
            else if (data_wr[i]) wptr_hi[i] <= !wptr_hi[i];
        end

        // Read byte pointer: cleared by a control word, toggled per read.
        always_ff @(posedge clk) begin
            if (!rst_n)          rptr_hi[i] <= 1'b0;
            else if (ctrl_wr[i]) rptr_hi[i] <= 1'b0;
            else if (data_rd[i]) rptr_hi[i] <= !rptr_hi[i];
        end
    end

    // Read mux: the selected byte of the addressed channel, 0 otherwise.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (data_rd[i])
                rdata = rptr_hi[i] ? cnt_flat[i*CNT_W+DATA_W +: DATA_W]
                                   : cnt_flat[i*CNT_W +: DATA_W];
        end
    end
endmodule

// File: rtl/tmr_trig_det.sv
// Gate rising-edge detector that holds the edge until the next count tick
// consumes it.
// Assumes: the gate is already synchronous to clk.
module tmr_trig_det (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic clr,
    output logic trig_now
);
    logic gate_q, trig_q, rise;

    assign rise     = gate && !gate_q;
    assign trig_now = trig_q || rise;

    // Keep last gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    // Hold a seen edge until a tick (or control write) clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    trig_q <= 1'b0;
        else if (clr)  trig_q <= 1'b0;
        else if (rise) trig_q <= 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: a down-counter with a reload register and an output
// waveform chosen by the programmed mode.
// Assumes: ce is a one-clock tick enable, a reload of 0 stands for 2**CNT_W,
// and modes 2 and 3 use counts of 2 or more.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [MODE_W-1:0] ctrl_mode,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ce,
    input  logic              gate,
    output logic              out,
    output logic [CNT_W-1:0]  count,
    output logic [MODE_W-1:0] mode,
    output logic              configured
);
    tmr_mode_e        mode_q;
    logic [CNT_W-1:0] reload_q, count_q, dec;
    logic [CNT_W:0]   half;
    logic             armed_q, pend_q, run_q, out_q, cfg_q, trig_now;
    logic             trig_mode, hold_mode;

    tmr_trig_det u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .clr      (ce || ctrl_wr),
        .trig_now (trig_now)
    );

    // Derived terms: decrement, half period, and mode classes.
    always_comb begin
        dec       = count_q - 1'b1;
        half      = {(reload_q == '0), reload_q} >> 1;
        trig_mode = (mode_q == M_ONESHOT) || (mode_q == M_HWSTROBE);
        hold_mode = (mode_q == M_RATE) || (mode_q == M_SQUARE);
    end

    // Channel state: configuration, load, counting and output waveform.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= 1'b0;
            mode_q   <= M_TCINT;
            reload_q <= '0;
            count_q  <= '0;
            armed_q  <= 1'b0;
            pend_q   <= 1'b0;
            run_q    <= 1'b0;
            out_q    <= 1'b1;
        end else if (ctrl_wr) begin
            cfg_q   <= 1'b1;
            mode_q  <= tmr_mode_e'(ctrl_mode);
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            run_q   <= 1'b0;
            out_q   <= (tmr_mode_e'(ctrl_mode) != M_TCINT);
        end else if (cfg_q) begin
            if (hold_mode && !gate) out_q <= 1'b1;
            if (ce) begin
                unique case (mode_q)
                    M_TCINT: begin
                        if (pend_q) begin
                            count_q <= reload_q;
                            pend_q  <= 1'b0;
                            run_q   <= 1'b1;
                        end else if (run_q && gate) begin
                            count_q <= dec;
                            if (count_q == 1) out_q <= 1'b1;
                        end
                    end
                    M_ONESHOT: begin
                        if (trig_now && armed_q) begin
                            count_q <= reload_q;
                            out_q   <= 1'b0;
                            run_q   <= 1'b1;
                        end else if (run_q) begin
                            count_q <= dec;
                            if (count_q == 1) begin
                                out_q <= 1'b1;
                                run_q <= 1'b0;
                            end
                        end
                    end
                    M_RATE, M_SQUARE: begin
                        if (gate) begin
                            if (pend_q || (trig_now && armed_q)) begin
                                count_q <= reload_q;
                                pend_q  <= 1'b0;
                                run_q   <= 1'b1;
                                out_q   <= 1'b1;
                            end else if (run_q) begin
                                if (count_q == 1) begin
                                    count_q <= reload_q;
                                    out_q   <= 1'b1;
                                end else begin
                                    count_q <= dec;
                                    out_q   <= (mode_q == M_RATE) ? (dec != 1)
                                                                  : ({1'b0, dec} > half);
                                end
                            end
                        end
                    end
                    M_SWSTROBE, M_HWSTROBE: begin
                        if (!out_q) out_q <= 1'b1;
                        if ((mode_q == M_SWSTROBE) ? pend_q : (trig_now && armed_q)) begin
                            count_q <= reload_q;
                            pend_q  <= 1'b0;
                            run_q   <= 1'b1;
                        end else if (run_q && (gate || mode_q == M_HWSTROBE)) begin
                            count_q <= dec;
                            if (count_q == 1) begin
                                out_q <= 1'b0;
                                run_q <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (lo_wr) reload_q[DATA_W-1:0] <= wdata;
            if (hi_wr) begin
                reload_q[CNT_W-1:DATA_W] <= wdata;
                armed_q <= 1'b1;
                if (!trig_mode) pend_q <= 1'b1;
                if (mode_q == M_TCINT) begin
                    out_q <= 1'b0;
                    run_q <= 1'b0;
                end
                if (mode_q == M_SWSTROBE) run_q <= 1'b0;
            end
        end
    end

    assign out        = out_q;
    assign count      = count_q;
    assign mode       = mode_q;
    assign configured = cfg_q;
endmodule

// File: rtl/tmr_multi_top.sv
// Top of the three-channel interval timer: one bus decoder and NUM_CH
// channels, each with its own tick enable, gate and output.
// Assumes: all inputs are synchronous to clk.
module tmr_multi_top
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_CH-1:0] cnt_en,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] tmr_out
);
    localparam int CNT_W = 2 * DATA_W;

    logic [NUM_CH*CNT_W-1:0]  cnt_flat;
    logic [NUM_CH*MODE_W-1:0] mode_flat;
    logic [NUM_CH-1:0]        cfg_vec, ctrl_wr, lo_wr, hi_wr;
    logic [MODE_W-1:0]        ctrl_mode;

    tmr_bus_if #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .wdata     (wdata),
        .cnt_flat  (cnt_flat),
        .rdata     (rdata),
        .ctrl_wr   (ctrl_wr),
        .ctrl_mode (ctrl_mode),
        .lo_wr     (lo_wr),
        .hi_wr     (hi_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        tmr_channel #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_wr    (ctrl_wr[i]),
            .ctrl_mode  (ctrl_mode),
            .lo_wr      (lo_wr[i]),
            .hi_wr      (hi_wr[i]),
            .wdata      (wdata),
            .ce         (cnt_en[i]),
            .gate       (gate[i]),
            .out        (tmr_out[i]),
            .count      (cnt_flat[i*CNT_W +: CNT_W]),
            .mode       (mode_flat[i*MODE_W +: MODE_W]),
            .configured (cfg_vec[i])
        );
    end
endmodule

// File: rtl/tmr_multi_chk.sv
// Property checker for the interval timer, attached to the top by bind.
// Assumes: the mode codes of tmr_pkg.
module tmr_multi_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     rd_n,
    input logic                     wr_n,
    input logic [1:0]               addr,
    input logic [DATA_W-1:0]        rdata,
    input logic [NUM_CH-1:0]        cnt_en,
    input logic [NUM_CH-1:0]        gate,
    input logic [NUM_CH-1:0]        tmr_out,
    input logic [NUM_CH*MODE_W-1:0] mode_flat,
    input logic [NUM_CH-1:0]        cfg_vec
);
    logic any_wr;
    assign any_wr = !cs_n && !wr_n;

    // Reset forces every output high on the next clock.
    assert_reset_out_high_R1: assert property (@(posedge clk)
        !rst_n |=> (tmr_out == '1));

    // A read of the control word address returns zero.
    assert_ctrl_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && wr_n && addr == 2'b11) |-> (rdata == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
        // Output only moves on a tick, a bus write, or a low gate.
        assert_out_needs_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_en[i] && !any_wr && gate[i]) |=> $stable(tmr_out[i]));

        // In mode 0 a high output never falls without a bus write.
        assert_tc_no_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_vec[i] && mode_flat[i*MODE_W +: MODE_W] == M_TCINT
             && tmr_out[i] && !any_wr) |=> tmr_out[i]);

        // A strobe low lasts no more than one tick.
        assert_strobe_one_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_vec[i] && (mode_flat[i*MODE_W +: MODE_W] == M_SWSTROBE
                            || mode_flat[i*MODE_W +: MODE_W] == M_HWSTROBE)
             && !tmr_out[i] && cnt_en[i]) |=> tmr_out[i]);
    end
endmodule

bind tmr_multi_top tmr_multi_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .rdata     (rdata),
    .cnt_en    (cnt_en),
    .gate      (gate),
    .tmr_out   (tmr_out),
    .mode_flat (mode_flat),
    .cfg_vec   (cfg_vec)
);

// File: tb/tmr_multi_top_tb.sv
// Self-checking bench: sweeps all modes, channels and small counts, and
// covers the bus and gate corner cases.
module tmr_multi_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] cnt_en = '0;
    logic [2:0] gate = 3'b111;
    logic [2:0] tmr_out;
    int total = 0;
    int bad = 0;

    always #4 clk = !clk;

    tmr_multi_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en),
        .gate(gate), .tmr_out(tmr_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic tick();
        @(negedge clk);
        cnt_en = 3'b111;
        @(negedge clk);
        cnt_en = 3'b000;
    endtask

    function automatic logic [7:0] cw(input int ch, input int md);
        return 8'((ch << 6) | 8'h30 | (md << 1));
    endfunction

    function automatic int exp_out(input int md, input int n, input int k);
        case (md)
            0, 1:    return (k >= n + 1) ? 1 : 0;
            2:       return (k % n != 0) ? 1 : 0;
            3:       return ((n - ((k - 1) % n)) > n / 2) ? 1 : 0;
            default: return (k != n + 1) ? 1 : 0;
        endcase
    endfunction

    function automatic string mtag(input int md);
        case (md)
            0: return "R5";  1: return "R7";  2: return "R8";
            3: return "R9";  4: return "R10"; default: return "R11";
        endcase
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, unconfigured channels ignore ticks.
        chk("R1 out after reset", tmr_out, 3'b111);
        tick(); tick();
        chk("R1 unconfigured ticks", tmr_out, 3'b111);
        bus_rd(2'd0, rb);
        chk("R1 read after reset", rb, 0);

        // R2/R3: ignored control writes leave channel 0 in mode 0 (out low).
        bus_wr(2'd3, cw(0, 0), 1'b0);
        chk("R3 mode0 out low", tmr_out[0], 0);
        bus_wr(2'd3, cw(0, 4) | 8'h01, 1'b0);
        chk("R3 bit0 set ignored", tmr_out[0], 0);
        bus_wr(2'd3, cw(0, 4), 1'b1);
        chk("R2 cs high ignored", tmr_out[0], 0);
        bus_wr(2'd3, 8'h18, 1'b0);
        chk("R3 bits5:4 not 11 ignored", tmr_out[0], 0);
        bus_wr(2'd3, 8'h3C, 1'b0);
        chk("R3 mode6 ignored", tmr_out[0], 0);
        bus_wr(2'd3, 8'hC0 | 8'h30, 1'b0);
        chk("R3 channel 3 ignored", tmr_out, 3'b110);
        bus_wr(2'd3, cw(0, 4), 1'b0);
        chk("R3 valid mode4 out high", tmr_out[0], 1);

        // Sweep: every channel, mode and small count.
        for (int ch = 0; ch < 3; ch++) begin
            for (int md = 0; md < 6; md++) begin
                for (int n = ((md == 2 || md == 3) ? 2 : 1); n <= 7; n++) begin
                    int kmax;
                    bit trg;
                    trg = (md == 1 || md == 5);
                    @(negedge clk);
                    gate[ch] = !trg;
                    @(negedge clk);
                    bus_wr(2'd3, cw(ch, md), 1'b0);
                    chk("R3 initial out", tmr_out[ch], (md == 0) ? 0 : 1);
                    bus_wr(2'(ch), 8'(n), 1'b0);
                    bus_wr(2'(ch), 8'h00, 1'b0);
                    tick();
                    if (trg) begin
                        // R4: gate-triggered modes ignore the count until an edge.
                        chk("R4 no start before edge", tmr_out[ch], 1);
                        @(negedge clk);
                        gate[ch] = 1'b1;
                    end
                    kmax = (md == 2 || md == 3) ? 2 * n + 2 : n + 3;
                    for (int k = (trg ? 1 : 2); k <= kmax; k++) begin
                        if (!(trg && k == 1) || trg) begin
                            if (!trg && k == 2) chk("R4 first tick load", tmr_out[ch],
                                                    exp_out(md, n, 1));
                        end
                        tick();
                        chk(mtag(md), tmr_out[ch], exp_out(md, n, k));
                    end
                end
            end
        end

        // R7: one-shot retrigger restarts the low pulse.
        @(negedge clk); gate[1] = 1'b0;
        bus_wr(2'd3, cw(1, 1), 1'b0);
        bus_wr(2'd1, 8'd3, 1'b0); bus_wr(2'd1, 8'd0, 1'b0);
        @(negedge clk); gate[1] = 1'b1;
        tick(); tick();
        @(negedge clk); gate[1] = 1'b0;
        @(negedge clk); gate[1] = 1'b1;
        tick(); tick(); tick();
        chk("R7 retrigger still low", tmr_out[1], 0);
        tick();
        chk("R7 retrigger ends", tmr_out[1], 1);

        // R6: mode 0 count frozen while gate low.
        @(negedge clk); gate[2] = 1'b1;
        bus_wr(2'd3, cw(2, 0), 1'b0);
        bus_wr(2'd2, 8'd5, 1'b0); bus_wr(2'd2, 8'd0, 1'b0);
        tick(); tick(); tick();
        @(negedge clk); gate[2] = 1'b0;
        for (int j = 0; j < 6; j++) tick();
        chk("R6 held while gate low", tmr_out[2], 0);
        @(negedge clk); gate[2] = 1'b1;
        tick(); tick();
        chk("R6 one count left", tmr_out[2], 0);
        tick();
        chk("R6 terminal after resume", tmr_out[2], 1);

        // R8: square/rate output forced high while gate low.
        bus_wr(2'd3, cw(0, 3), 1'b0);
        @(negedge clk); gate[0] = 1'b1;
        bus_wr(2'd0, 8'd4, 1'b0); bus_wr(2'd0, 8'd0, 1'b0);
        tick(); tick(); tick();
        chk("R9 low half reached", tmr_out[0], 0);
        @(negedge clk); gate[0] = 1'b0;
        @(negedge clk);
        chk("R8 gate low forces high", tmr_out[0], 1);
        gate[0] = 1'b1;

        // R12/R2: byte readback with control-address read in between.
        bus_wr(2'd3, cw(1, 0), 1'b0);
        @(negedge clk); gate[1] = 1'b1;
        bus_wr(2'd1, 8'h34, 1'b0); bus_wr(2'd1, 8'h12, 1'b0);
        for (int j = 0; j < 5; j++) tick();
        bus_rd(2'd1, rb);
        chk("R12 low byte", rb, 8'h30);
        bus_rd(2'd3, rb);
        chk("R2 control read zero", rb, 0);
        bus_rd(2'd1, rb);
        chk("R12 high byte", rb, 8'h12);

        // R4: count 0 means 65536 ticks.
        bus_wr(2'd3, cw(2, 0), 1'b0);
        bus_wr(2'd2, 8'h00, 1'b0); bus_wr(2'd2, 8'h00, 1'b0);
        @(negedge clk);
        cnt_en = 3'b100;
        repeat (65536) @(negedge clk);
        chk("R4 zero count not yet", tmr_out[2], 0);
        @(negedge clk);
        cnt_en = 3'b000;
        chk("R4 zero count is 65536", tmr_out[2], 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule